// File: doc/BRIEF.md
# Overclock Watchdog with Safe-Frequency Fallback

This block protects a programmable clock setup against a configuration that runs the system too fast to work. Software arms it, then services it regularly. If it goes unserviced for a programmed number of seconds, three things happen. The block pulses an active-low system reset for a fixed number of clocks. It raises a sticky timeout flag. It forces the frequency selection to a safe code that software stored earlier. The safe code stays in force until software clears the flag.

The block keeps no real-time clock of its own. A one-clock tick-enable marks each elapsed second, and only those ticks advance the countdown. Two registers come from the serial configuration interface, each with its own write strobe:

- **Timeout count**: 8 bits, whole seconds.
- **Control**: holds the enable, the flag, the safe code and the frequency-source bit.

All pins are plain level or strobe signals. There is no streaming interface, so there is no back-pressure to honour. The frequency code is a pure function of register state and the two candidate codes.

Top module: `wdg_guard`

## Requirements
- R1: After reset, `sys_rst_n` is 1, `wd_status` is 0, `freq_src` is 0 and `freq_code` equals `strap_code`. The timeout count is 16, so with the enable set the 16th tick expires and the 15th does not.
- R2: While enabled, the countdown expires on the Nth tick after its last reload, where N is the count. A count of 0 behaves like 1. In the clock after the expiring tick, `sys_rst_n` is 0.
- R3: A `kick` pulse reloads the countdown from the count register, so a full N further ticks are needed to expire.
- R4: A write to the count register (`cnt_wr` with `cnt_wdata`) stores the new value and reloads the countdown with it in the same cycle. It takes precedence over a simultaneous kick or tick.
- R5: With control bit 0 (enable) at 0, ticks have no effect: no expiry occurs. The countdown holds the full count, so re-enabling needs N new ticks.
- R6: The reset pulse on `sys_rst_n` lasts exactly RST_CYC clocks (default 8), then `sys_rst_n` returns to 1.
- R7: Control bit 1 is the timeout flag (`wd_status`). It is set by an expiry and stays set. A control write with bit 1 = 0 clears it, and a control write with bit 1 = 1 never sets it.
- R8: While `wd_status` is 1, `freq_code` equals control bits [6:2] (the safe code) and `freq_src` is 0, whatever the value of bit 7.
- R9: While `wd_status` is 0, control bit 7 = 0 selects `strap_code` with `freq_src` = 0, and bit 7 = 1 selects `div_code` with `freq_src` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 1 | Write strobe for the timeout count register |
| cnt_wdata | input | 8 | Timeout count in seconds |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control: [0] enable, [1] flag, [6:2] safe code, [7] source select |
| kick | input | 1 | Service pulse, reloads the countdown |
| tick_1s | input | 1 | One-clock pulse per elapsed second |
| strap_code | input | 5 | Frequency code from straps or the basic select byte |
| div_code | input | 5 | Frequency code from the direct divider registers |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| wd_status | output | 1 | Sticky timeout flag |
| freq_src | output | 1 | 1 when the direct divider registers drive the frequency |
| freq_code | output | 5 | Active frequency selection code |

## Verification
A corrupted countdown is only visible as the timing of the reset pulse. If the remaining count is off by one, `sys_rst_n` falls one tick early or late, which is one second of tick time after the last reload. That is why each scenario counts ticks up to the exact expiry. A lost or spurious flag shows at once on `wd_status` and within the same clock on `freq_code`, because the code mux depends only on register state. A wrong pulse counter shows as a low phase on `sys_rst_n` of the wrong length, visible within RST_CYC clocks of the expiry.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int SAFE_W = 5;

  // Control register image; bit positions are decoded by software.
  typedef struct packed {
    logic              src;   // [7] frequency source select
    logic [SAFE_W-1:0] safe;  // [6:2] safe frequency code
    logic              st;    // [1] timeout flag
    logic              en;    // [0] watchdog enable
  } wdg_ctl_t;

  localparam int CTL_W = $bits(wdg_ctl_t);
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int CNT_RST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ctl_wr,
  input  wdg_ctl_t         ctl_wdata,
  input  logic             expire,
  output logic [CNT_W-1:0] cnt_q,
  output wdg_ctl_t         ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(CNT_RST);
    end else if (cnt_wr) begin
      cnt_q <= cnt_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (ctl_wr) begin
        ctl_q.en   <= ctl_wdata.en;
        ctl_q.safe <= ctl_wdata.safe;
        ctl_q.src  <= ctl_wdata.src;
      end
      // Flag: set by expiry, cleared only by writing 0, never set by software.
      if (expire)
        ctl_q.st <= 1'b1;
      else if (ctl_wr && !ctl_wdata.st)
        ctl_q.st <= 1'b0;
    end
  end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int CNT_W   = 8,
  parameter int CNT_RST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             kick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             expire,
  output logic [CNT_W-1:0] remain
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic reload;

  assign expire = en && tick && !kick && !cnt_wr && (remain <= ONE);
  assign reload = kick || !en || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= CNT_W'(CNT_RST);
    end else if (cnt_wr) begin
      remain <= cnt_wdata;
    end else if (reload) begin
      remain <= cnt_q;
    end else if (tick) begin
      remain <= remain - ONE;
    end
  end
endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
  parameter int RST_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  output logic sys_rst_n
);
  localparam int PW = $clog2(RST_CYC + 1);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (expire) begin
      left <= PW'(RST_CYC);
    end else if (left != '0) begin
      left <= left - PW'(1);
    end
  end

  assign sys_rst_n = (left == '0);
endmodule

// File: rtl/wdg_freq_mux.sv
module wdg_freq_mux
  import wdg_pkg::*;
(
  input  wdg_ctl_t          ctl_q,
  input  logic [SAFE_W-1:0] strap_code,
  input  logic [SAFE_W-1:0] div_code,
  output logic              freq_src,
  output logic [SAFE_W-1:0] freq_code
);
  always_comb begin
    if (ctl_q.st) begin
      freq_src  = 1'b0;
      freq_code = ctl_q.safe;
    end else if (ctl_q.src) begin
      freq_src  = 1'b1;
      freq_code = div_code;
    end else begin
      freq_src  = 1'b0;
      freq_code = strap_code;
    end
  end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int CNT_RST = 16,
  parameter int RST_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              kick,
  input  logic              tick_1s,
  input  logic [SAFE_W-1:0] strap_code,
  input  logic [SAFE_W-1:0] div_code,
  output logic              sys_rst_n,
  output logic              wd_status,
  output logic              freq_src,
  output logic [SAFE_W-1:0] freq_code
);
  wdg_ctl_t         ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] remain;
  logic             expire;

  wdg_regs #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (wdg_ctl_t'(ctl_wdata)),
    .expire    (expire),
    .cnt_q     (cnt_q),
    .ctl_q     (ctl_q)
  );

  wdg_timer #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctl_q.en),
    .tick      (tick_1s),
    .kick      (kick),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .cnt_q     (cnt_q),
    .expire    (expire),
    .remain    (remain)
  );

  wdg_rst_pulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .sys_rst_n (sys_rst_n)
  );

  wdg_freq_mux u_mux (
    .ctl_q      (ctl_q),
    .strap_code (strap_code),
    .div_code   (div_code),
    .freq_src   (freq_src),
    .freq_code  (freq_code)
  );

  assign wd_status = ctl_q.st;
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
  parameter int CNT_W   = 8,
  parameter int RST_CYC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             kick,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] remain,
  input logic             expire,
  input logic             ctl_wr,
  input logic             sys_rst_n,
  input logic             wd_status
);
  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= 0;
    else if (!sys_rst_n) low_run <= low_run + 1;
    else                 low_run <= 0;
  end

  p_expire_pulls_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!sys_rst_n && wd_status));

  p_kick_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !cnt_wr) |=> (remain == $past(cnt_q)));

  p_cnt_write_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (remain == $past(cnt_wdata) && cnt_q == $past(cnt_wdata)));

  p_disabled_no_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !expire);

  p_pulse_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= RST_CYC);

  p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_status && !ctl_wr) |=> wd_status);
endmodule

bind wdg_guard wdg_guard_chk #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (ctl_q.en),
  .kick      (kick),
  .cnt_wr    (cnt_wr),
  .cnt_wdata (cnt_wdata),
  .cnt_q     (cnt_q),
  .remain    (remain),
  .expire    (expire),
  .ctl_wr    (ctl_wr),
  .sys_rst_n (sys_rst_n),
  .wd_status (wd_status)
);

// File: tb/wdg_guard_tb.sv
`timescale 1ns/1ps
module wdg_guard_tb;
  localparam int RST_CYC = 8;
  localparam logic [4:0] STRAP = 5'h13;
  localparam logic [4:0] DIV   = 5'h06;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_wr = 1'b0, ctl_wr = 1'b0, kick = 1'b0, tick_1s = 1'b0;
  logic [7:0] cnt_wdata = '0, ctl_wdata = '0;
  logic       sys_rst_n, wd_status, freq_src;
  logic [4:0] freq_code;

  int checks = 0, errors = 0, cyc = 0;

  // behavioural reference state
  int m_cnt = 16, m_rem = 16, m_left = 0;
  int m_en = 0, m_st = 0, m_safe = 0, m_src = 0;

  always #4 clk = ~clk;

  wdg_guard #(.RST_CYC(RST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .kick(kick), .tick_1s(tick_1s),
    .strap_code(STRAP), .div_code(DIV), .sys_rst_n(sys_rst_n),
    .wd_status(wd_status), .freq_src(freq_src), .freq_code(freq_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 16; m_rem = 16; m_left = 0;
      m_en = 0; m_st = 0; m_safe = 0; m_src = 0;
    end else begin
      bit ex;
      ex = m_en && tick_1s && !kick && !cnt_wr && (m_rem <= 1);
      if (cnt_wr) m_rem = cnt_wdata;
      else if (kick || !m_en || ex) m_rem = m_cnt;
      else if (tick_1s) m_rem = m_rem - 1;
      if (cnt_wr) m_cnt = cnt_wdata;
      if (ctl_wr) begin
        m_en = ctl_wdata[0]; m_safe = ctl_wdata[6:2]; m_src = ctl_wdata[7];
        if (!ctl_wdata[1]) m_st = 0;
      end
      if (ex) begin m_st = 1; m_left = RST_CYC; end
      else if (m_left > 0) m_left = m_left - 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    int ef, es;
    ef = m_st ? m_safe : (m_src ? DIV : STRAP);
    es = m_st ? 0 : m_src;
    chk("R6 sys_rst_n", sys_rst_n, (m_left == 0));
    chk("R7 wd_status", wd_status, m_st);
    chk("R8/R9 freq_code", freq_code, ef);
    chk("R8/R9 freq_src", freq_src, es);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input bit c_wr, input int c_d, input bit k_wr,
                      input int k_d, input bit kk, input bit tk);
    @(negedge clk);
    cnt_wr = c_wr; cnt_wdata = 8'(c_d); ctl_wr = k_wr; ctl_wdata = 8'(k_d);
    kick = kk; tick_1s = tk;
    @(negedge clk);
    cnt_wr = 0; ctl_wr = 0; kick = 0; tick_1s = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 40; i++) if (!sys_rst_n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset sys_rst_n", sys_rst_n, 1);
    chk("R1 reset status", wd_status, 0);
    chk("R1 reset freq_code", freq_code, STRAP);
    chk("R1 reset freq_src", freq_src, 0);

    // R1: default count of 16, enable with safe code 0x0A
    step(0, 0, 1, 8'h29, 0, 0);
    ticks(15);
    chk("R1 no expiry at 15", sys_rst_n, 1);
    ticks(1);
    chk("R1 expiry at 16", sys_rst_n, 0);
    chk("R7 flag set", wd_status, 1);
    chk("R8 safe code", freq_code, 5'h0A);

    // R6: pulse length, counted from the first low clock
    begin
      int lows = 1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!sys_rst_n) lows++;
      end
      chk("R6 pulse length", lows, RST_CYC);
    end

    // R8: source bit ignored while flag set
    step(0, 0, 1, 8'hAB, 0, 0);
    chk("R8 src ignored", freq_src, 0);
    chk("R7 write 1 keeps flag", wd_status, 1);
    // R7/R9: clear flag, direct source
    step(0, 0, 1, 8'hA9, 0, 0);
    chk("R7 flag cleared", wd_status, 0);
    chk("R9 direct code", freq_code, DIV);
    chk("R9 direct src", freq_src, 1);
    step(0, 0, 1, 8'h2B, 0, 0);
    chk("R7 write 1 never sets", wd_status, 0);
    chk("R9 strap code", freq_code, STRAP);

    // R4: count write reloads
    step(1, 3, 0, 0, 0, 0);
    ticks(2);
    chk("R4 no expiry at 2", sys_rst_n, 1);
    // R3: kick reloads to 3
    step(0, 0, 0, 0, 1, 0);
    ticks(2);
    chk("R3 no expiry after kick", sys_rst_n, 1);
    ticks(1);
    chk("R3 expiry after 3", sys_rst_n, 0);
    wait_release();

    // R4: write wins over simultaneous tick
    step(0, 0, 1, 8'h29, 0, 0);
    step(1, 1, 0, 0, 0, 1);
    chk("R4 write beats tick", sys_rst_n, 1);
    ticks(1);
    chk("R4 count 1 expires", sys_rst_n, 0);
    wait_release();

    // R2: count 0 behaves like 1
    step(0, 0, 1, 8'h29, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    ticks(1);
    chk("R2 zero count", sys_rst_n, 0);
    wait_release();

    // R5: disable holds, re-enable needs full count
    step(0, 0, 1, 8'h29, 0, 0);
    step(1, 5, 0, 0, 0, 0);
    ticks(3);
    step(0, 0, 1, 8'h28, 0, 0);
    ticks(30);
    chk("R5 disabled no expiry", sys_rst_n, 1);
    chk("R5 disabled no flag", wd_status, 0);
    step(0, 0, 1, 8'h29, 0, 0);
    ticks(4);
    chk("R5 reload on enable", sys_rst_n, 1);
    ticks(1);
    chk("R5 expiry after full count", sys_rst_n, 0);
    wait_release();
    chk("R2 flag after expiry", wd_status, 1);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule